// File: doc/BRIEF.md
# Microsecond Countdown Timer

This peripheral lets software measure or wait out short intervals in whole microseconds. It sits on a simple memory-mapped register bus with an active-high select strobe and a write-enable. One register holds a 16-bit count. Writing to it starts a countdown that drops by one each microsecond. A second, narrow register carries an expiry flag and an interrupt-enable flag. A parameterised prescaler derives the microsecond tick from the system clock, so the longest interval is 65535 µs.

Software writes a count of microseconds and then either polls the expiry flag or enables the interrupt. Once the count runs out, the flag stays set and the counter stays at zero until the next count is written. To wait one millisecond, write 1000 and poll until the flag reads as one. The interrupt request is the expiry flag gated by the enable flag.

Top module: `usTimer`

## Requirements
- R1: After reset the count reads 0, the status register reads 0x0001 (expired, interrupt disabled) and `irq` is 0.
- R2: A write at address 0x20 loads `wdata` into the count, clears the expiry flag (status bit 0) and restarts the prescaler.
- R3: The count drops by one every PRESCALE clock cycles. The first drop takes effect PRESCALE cycles after the edge that loaded it, and reads taken in between return the loaded value.
- R4: After a count N ≥ 1 is written, the expiry flag sets on the edge N·PRESCALE cycles after the load edge. From then on the count holds at 0 and does not wrap.
- R5: Writing a count of 0 sets the expiry flag after one tick, PRESCALE cycles after the load edge.
- R6: The status register is at address 0x24. Bit 7 is the interrupt enable and can be read and written. Bit 0 is the expiry flag and is read-only, so written values of bit 0 are ignored. All other bits read 0.
- R7: `irq` is high exactly when the expiry flag and the interrupt enable are both set.
- R8: A read strobe returns data on `rdata` in the next cycle and `rdata` holds its value until the next read. A read of any other address returns 0, and a write to any other address changes nothing.
- R9: Writing the count while a countdown is running abandons that countdown and starts timing the new value from the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read, qualified by busSel |
| busAddr | input | 8 | Byte address within the peripheral |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Read data appears one cycle after the strobe edge and reflects the register value before that edge. An expiry falls exactly N·PRESCALE edges after the load edge, and a count decrement falls on each multiple of PRESCALE after it. The bench timestamps each load edge with a cycle counter. From the requirements alone it computes the count and flag that should be visible at the edge a read will use, and pushes that value into a queue before driving the read. A monitor pops and compares each value in the cycle after its strobe. Reads are placed at cycle offsets PRESCALE−1 and PRESCALE so that an off-by-one in the timing shows up. `irq` and the holding of `rdata` are sampled at the falling edge.

// File: rtl/tmrPkg.sv
package tmrPkg;

  // Strobes issued by the control to the datapath, one cycle each.
  typedef struct packed {
    logic loadCount;   // bus write of the count register
    logic writeCtl;    // bus write of the status/control register
    logic readCount;   // bus read of the count register
    logic readCtl;     // bus read of the status/control register
    logic readNone;    // bus read of an unmapped address
    logic tick;        // one-microsecond enable
  } tmrStrobes_t;

endpackage

// File: rtl/tmrCtrl.sv
module tmrCtrl
  import tmrPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRESCALE = 50,
  parameter logic [ADDR_W-1:0] CNT_OFS = 'h20,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output tmrStrobes_t       strb
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic hitCnt, hitCtl, atLast;

  assign hitCnt = busSel && (busAddr == CNT_OFS);
  assign hitCtl = busSel && (busAddr == CTL_OFS);
  assign atLast = (preCnt == PRE_LAST);

  always_comb begin
    strb.loadCount = hitCnt && busWr;
    strb.writeCtl  = hitCtl && busWr;
    strb.readCount = hitCnt && !busWr;
    strb.readCtl   = hitCtl && !busWr;
    strb.readNone  = busSel && !busWr && !hitCnt && !hitCtl;
    strb.tick      = atLast && !strb.loadCount;
  end

  // Prescaler: a count write restarts the microsecond phase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strb.loadCount || atLast) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // R8
  one_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadCount, strb.writeCtl, strb.readCount, strb.readCtl, strb.readNone}));

  generate
    if (PRESCALE > 1) begin : gSpacing
      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.tick |=> !strb.tick);
      // R2
      restart_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.loadCount |=> !strb.tick);
    end
  endgenerate

endmodule

// File: rtl/tmrData.sv
module tmrData
  import tmrPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W = 16,
  parameter int IE_BIT = 7,
  parameter int RD_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic [CNT_W-1:0]  count;
  logic              rdFlag;
  logic              ieFlag;
  logic [DATA_W-1:0] rdataQ;
  logic [DATA_W-1:0] statusWord;

  // Countdown and expiry flag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      rdFlag <= 1'b1;
    end else if (strb.loadCount) begin
      count  <= wdata[CNT_W-1:0];
      rdFlag <= 1'b0;
    end else if (strb.tick && !rdFlag) begin
      if (count <= CNT_W'(1)) begin
        count  <= '0;
        rdFlag <= 1'b1;
      end else begin
        count <= count - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieFlag <= 1'b0;
    end else if (strb.writeCtl) begin
      ieFlag <= wdata[IE_BIT];
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[IE_BIT] = ieFlag;
    statusWord[RD_BIT] = rdFlag;
  end

  // Registered read port, holds between reads.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strb.readCount) begin
      rdataQ <= DATA_W'(count);
    end else if (strb.readCtl) begin
      rdataQ <= statusWord;
    end else if (strb.readNone) begin
      rdataQ <= '0;
    end
  end

  assign rdata = rdataQ;
  assign irq   = rdFlag & ieFlag;

  // R2
  load_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCount |=> (!rdFlag && count == $past(wdata[CNT_W-1:0])));
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadCount || strb.tick) |=> $stable(count));
  // R4
  expiry_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdFlag) |-> $past(strb.tick));
  // R4
  expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdFlag && !strb.loadCount) |=> (rdFlag && count == '0));
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.readCount || strb.readCtl || strb.readNone) |=> $stable(rdataQ));

endmodule

// File: rtl/usTimer.sv
module usTimer
  import tmrPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W = 16,
  parameter int PRESCALE = 50,
  parameter logic [ADDR_W-1:0] CNT_OFS = 'h20,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  tmrStrobes_t strb;

  tmrCtrl #(
    .ADDR_W(ADDR_W), .PRESCALE(PRESCALE), .CNT_OFS(CNT_OFS), .CTL_OFS(CTL_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .strb(strb)
  );

  tmrData #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .IE_BIT(7), .RD_BIT(0)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

endmodule

// File: tb/sim_usTimer.sv
module sim_usTimer;

  localparam int P = 50;
  localparam logic [7:0] A_CNT = 8'h20;
  localparam logic [7:0] A_CTL = 8'h24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0;
  logic busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  // Model state from the requirements
  longint wEdge = -1000000;  // reset state behaves as long expired
  int lastN = 0;
  logic ieModel = 1'b0;

  string tagQ[$];
  logic [15:0] valQ[$];

  usTimer u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic expRd();
    longint m = cyc - wEdge;
    int n = (lastN == 0) ? 1 : lastN;
    return m >= longint'(n) * P;
  endfunction

  function automatic logic [15:0] expCnt();
    longint t = (cyc - wEdge) / P;
    return (t >= lastN) ? 16'd0 : 16'(lastN - t);
  endfunction

  function automatic logic [15:0] expCtl();
    return {8'h00, ieModel, 6'b0, expRd()};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idleTo(longint m);
    while (cyc - wEdge < m) @(negedge clk);
  endtask

  task automatic writeReg(logic [7:0] a, logic [15:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    if (a == A_CNT) begin wEdge = cyc; lastN = int'(d); end
    if (a == A_CTL) ieModel = d[7];
  endtask

  task automatic readReg(string tag, logic [7:0] a, logic [15:0] exp);
    tagQ.push_back(tag);
    valQ.push_back(exp);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic chkIrq(string tag);
    check(tag, {15'b0, irq}, {15'b0, ieModel & expRd()});
  endtask

  // Monitor: compare each read one cycle after its strobe edge
  initial begin
    forever begin
      logic pend;
      @(posedge clk);
      pend = busSel && !busWr;
      @(negedge clk);
      if (pend && rstN) begin
        string t;
        logic [15:0] v;
        t = tagQ.pop_front();
        v = valQ.pop_front();
        check(t, rdata, v);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    readReg("R1 count", A_CNT, 16'h0000);
    readReg("R1 status", A_CTL, 16'h0001);
    chkIrq("R1 irq");

    // R6 enable writable, bit 0 and others ignored; R7 irq
    writeReg(A_CTL, 16'h00FF);
    readReg("R6 status ie set", A_CTL, 16'h0081);
    chkIrq("R7 irq on");
    writeReg(A_CTL, 16'h0001);
    readReg("R6 status bit0 ignored", A_CTL, 16'h0001);
    chkIrq("R7 irq off");
    writeReg(A_CTL, 16'h0080);

    // R2 load clears flag, R3 decrement timing
    writeReg(A_CNT, 16'd3);
    readReg("R2 flag cleared", A_CTL, expCtl());
    chkIrq("R7 irq low while counting");
    idleTo(49);
    readReg("R3 before first tick", A_CNT, expCnt());
    readReg("R3 first tick", A_CNT, expCnt());
    idleTo(149);
    readReg("R4 not yet expired", A_CTL, expCtl());
    readReg("R4 expired", A_CTL, expCtl());
    chkIrq("R7 irq on expiry");
    idleTo(400);
    readReg("R4 stops at zero", A_CNT, expCnt());

    // R9 restart mid-countdown
    writeReg(A_CNT, 16'd5);
    idleTo(120);
    readReg("R9 running", A_CNT, expCnt());
    writeReg(A_CNT, 16'd2);
    idleTo(49);
    readReg("R9 restarted hold", A_CNT, expCnt());
    readReg("R9 restarted tick", A_CNT, expCnt());

    // R5 zero count
    writeReg(A_CNT, 16'd0);
    readReg("R5 flag low", A_CTL, expCtl());
    idleTo(49);
    readReg("R5 before tick", A_CTL, expCtl());
    readReg("R5 after tick", A_CTL, expCtl());

    // R8 unmapped access, hold
    writeReg(A_CNT, 16'd7);
    readReg("R8 unmapped read", 8'h10, 16'h0000);
    busSel = 1'b1; busWr = 1'b1; busAddr = 8'h10; wdata = 16'h1234;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    readReg("R8 count untouched", A_CNT, expCnt());
    idle(3);
    check("R8 rdata held", rdata, 16'd7);

    // R4 one-millisecond delay
    writeReg(A_CNT, 16'd1000);
    idleTo(49999);
    readReg("R4 1ms not yet", A_CTL, expCtl());
    readReg("R4 1ms expired", A_CTL, expCtl());
    chkIrq("R7 irq after 1ms");

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule